// File: doc/BRIEF.md
# Dadda Column-Compression Unsigned Multiplier

This block multiplies two unsigned operands and returns their full-width product. Every partial-product bit is the AND of one multiplicand bit and one multiplier bit. The bits are grouped into columns by weight. A fixed series of reduction stages then compresses the columns with full adders and half adders until no column holds more than two bits.

Each stage has a height limit. The limits are built backward from 2: each earlier limit is the largest integer not above 1.5 times the next one. This gives the stage limits 6, 4, 3 and 2 for 8-bit operands. Within a stage, adders are placed only in columns that would otherwise exceed the limit. Because of this, the tree uses few counters and leaves more work to the final two-row adder. With 8-bit operands the tree uses 35 full adders and 7 half adders.

A parameter selects either a ripple or a lookahead final adder. A second parameter places an optional register on the product, with an active-low asynchronous reset.

Top module: `dadda_mult`

## Requirements
- R1: `prod` equals the exact unsigned product `mcand * mplier` for every one of the 65536 pairs of 8-bit operands.
- R2: With `OUT_REG` = 1, the product of the operands present at a rising clock edge appears on `prod` right after that edge and holds until the next edge.
- R3: While `rst_n` is low, `prod` is 0, whatever the operands are.
- R4: If either operand is 0, the product is 0.
- R5: If one operand is 1, the product equals the other operand zero-extended to 16 bits.
- R6: Operands 255 and 255 give 65025 (0xFE01), with the carry running into the top product bit.
- R7: The ripple final adder (`CLA` = 0) and the lookahead final adder (`CLA` = 1) give identical products for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional product register |
| rst_n | input | 1 | Active-low asynchronous reset of the product register |
| mcand | input | W (8) | Unsigned multiplicand |
| mplier | input | W (8) | Unsigned multiplier |
| prod | output | 2W (16) | Unsigned product |

## Verification
Two actions can fall in the same cycle: the register loading a product and the reset clearing it. The bench provokes this by holding the largest operands steady while `rst_n` is low. It checks that `prod` stays 0 through the reset. It then checks that 0xFE01 appears on the first edge after `rst_n` rises. Otherwise the exhaustive sweep feeds each pair one cycle after the previous pair. Both final-adder variants are then compared against a multiply computed in the bench, so a stale value or a bit carried over from the earlier pair shows up as a mismatch.

// File: rtl/dadda_mult.sv
module dadda_mult #(
  parameter int W       = 8,
  parameter bit CLA     = 1'b0,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int P = 2 * W;
  localparam int R = W;

  typedef logic [P-1:0][R-1:0] mat_t;
  typedef int hv_t [P];

  function automatic int n_stages(input int w);
    int d = 2;
    int n = 0;
    while (d < w) begin
      n++;
      d = d * 3 / 2;
    end
    return n;
  endfunction

  function automatic int limit_at(input int k);
    int d = 2;
    for (int i = 0; i < k; i++) d = d * 3 / 2;
    return d;
  endfunction

  localparam int NST = n_stages(W);

  function automatic void stage(input mat_t mi, input hv_t hi, input int lim,
                                output mat_t mo, output hv_t ho);
    mo = '0;
    for (int j = 0; j < P; j++) ho[j] = 0;
    for (int j = 0; j < P; j++) begin
      int k, ex, nf, nh;
      logic x, y, z;
      k  = 0;
      ex = hi[j] + ho[j] - lim;
      nf = (ex > 0) ? ex / 2 : 0;
      nh = (ex > 0) ? ex % 2 : 0;
      for (int f = 0; f < R; f++) begin
        if (f < nf) begin
          x = mi[j][k]; y = mi[j][k+1]; z = mi[j][k+2];
          if (ho[j] < R) mo[j][ho[j]] = x ^ y ^ z;
          ho[j]++;
          if (j + 1 < P) begin
            if (ho[j+1] < R) mo[j+1][ho[j+1]] = (x & y) | (z & (x ^ y));
            ho[j+1]++;
          end
          k += 3;
        end
      end
      if (nh == 1) begin
        x = mi[j][k]; y = mi[j][k+1];
        if (ho[j] < R) mo[j][ho[j]] = x ^ y;
        ho[j]++;
        if (j + 1 < P) begin
          if (ho[j+1] < R) mo[j+1][ho[j+1]] = x & y;
          ho[j+1]++;
        end
        k += 2;
      end
      for (int r = 0; r < R; r++) begin
        if (r >= k && r < hi[j]) begin
          if (ho[j] < R) mo[j][ho[j]] = mi[j][r];
          ho[j]++;
        end
      end
    end
  endfunction

  mat_t         mat, nxt;
  hv_t          hgt, nhg;
  logic [P-1:0] row0, row1, sum;

  always_comb begin
    mat = '0;
    nxt = '0;
    for (int j = 0; j < P; j++) begin
      hgt[j] = 0;
      nhg[j] = 0;
    end
    for (int i = 0; i < W; i++)
      for (int k = 0; k < W; k++) begin
        mat[i+k][hgt[i+k]] = mcand[k] & mplier[i];
        hgt[i+k]++;
      end
    for (int s = 0; s < NST; s++) begin
      stage(mat, hgt, limit_at(NST - 1 - s), nxt, nhg);
      mat = nxt;
      hgt = nhg;
    end
    for (int j = 0; j < P; j++) begin
      row0[j] = mat[j][0];
      row1[j] = mat[j][1];
    end
  end

  // R1: the two rows left by the tree must already add up to the product
  always_comb begin
    if (!$isunknown({mcand, mplier}))
      a_r1_rows_sum: assert (row0 + row1 == P'(mcand) * P'(mplier));
  end

  if (CLA) begin : g_cla
    logic [P-1:0] gen, prp, cy;
    assign gen = row0 & row1;
    assign prp = row0 ^ row1;
    always_comb begin
      for (int i = 0; i < P; i++) begin
        cy[i] = 1'b0;
        for (int j = 0; j < i; j++) begin
          logic t;
          t = gen[j];
          for (int k = j + 1; k < i; k++) t = t & prp[k];
          cy[i] = cy[i] | t;
        end
      end
    end
    assign sum = prp ^ cy;
  end else begin : g_rca
    always_comb begin
      logic c;
      c = 1'b0;
      for (int i = 0; i < P; i++) begin
        sum[i] = row0[i] ^ row1[i] ^ c;
        c = (row0[i] & row1[i]) | (c & (row0[i] ^ row1[i]));
      end
    end
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prod <= '0;
      else        prod <= sum;

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> prod == P'($past(mcand)) * P'($past(mplier)));
    a_r3_reset_clear: assert property (@(posedge clk)
      !rst_n |=> prod == '0);
    a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (mcand == '0 || mplier == '0) |=> prod == '0);
    a_r5_unit_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (mplier == W'(1)) |=> prod == P'($past(mcand)));
  end else begin : g_comb
    assign prod = sum;
  end
endmodule

// File: tb/sim_dadda_mult.sv
`timescale 1ns/1ps
module sim_dadda_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mc = 8'd0, mp = 8'd0;
  logic [15:0] p_rca, p_cla;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dadda_mult #(.W(8), .CLA(1'b0), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .mcand(mc), .mplier(mp), .prod(p_rca));
  dadda_mult #(.W(8), .CLA(1'b1), .OUT_REG(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .mcand(mc), .mplier(mp), .prod(p_cla));

  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'd0,   8'd0,   16'd0},
    {8'd1,   8'd1,   16'd1},
    {8'd255, 8'd255, 16'd65025},
    {8'd255, 8'd1,   16'd255},
    {8'd0,   8'd200, 16'd0},
    {8'd128, 8'd128, 16'd16384},
    {8'd15,  8'd17,  16'd255},
    {8'd170, 8'd85,  16'd14450}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s mc=%0d mp=%0d got=%0d expected=%0d", req, mc, mp, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    mc = a;
    mp = b;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired got=running expected=finished");
    finish_run();
  end

  initial begin
    // R3: reset holds prod at 0 while large operands load at the same edges
    mc = 8'd255;
    mp = 8'd255;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset rca", p_rca, 16'd0);
    chk("R3 reset cla", p_cla, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 first load after reset", p_rca, 16'd65025);
    chk("R6 max operands", p_cla, 16'd65025);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][31:24], VEC[v][23:16]);
      chk("R1 table rca", p_rca, VEC[v][15:0]);
      chk("R7 table cla", p_cla, VEC[v][15:0]);
    end

    // R2: product holds between edges when operands change mid-cycle
    apply(8'd12, 8'd11);
    #1;
    mc = 8'd3;
    chk("R2 hold between edges", p_rca, 16'd132);
    @(posedge clk);
    #1;
    chk("R2 next edge", p_rca, 16'd33);

    for (int a = 0; a < 256; a++) begin
      apply(8'(a), 8'd0);
      chk("R4 zero operand", p_rca, 16'd0);
      apply(8'd1, 8'(a));
      chk("R5 unit operand", p_cla, 16'(a));
    end

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        apply(8'(a), 8'(b));
        chk("R1 exhaustive rca", p_rca, 16'(a * b));
        chk("R7 exhaustive cla", p_cla, 16'(a * b));
      end

    // R3: asynchronous clear in mid-cycle
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R3 async clear", p_rca, 16'd0);
    finish_run();
  end
endmodule